// File: doc/BRIEF.md
# Interrupt Vector Relocation Unit

This unit sits at the end of the interrupt entry path. The interrupt logic has already chosen the exception and computed two things: a base vector, and the machine-state word that the handler will run with. This unit decides whether that entry should be moved to the alternate, translated location. If it should, the unit turns on instruction and data relocation in the outgoing state word and adds the selected high offset to the vector.

Relocation depends on several conditions. The exception class must not be exempt. Both translation bits must be on in the running state. The configured processor model must support relocation. The 2-bit location mode must select one of the two active settings. An interrupt that raises the hypervisor bit is also filtered. One model always blocks relocation in that case. The other allows it when the partition runs in radix translation. Vectored system calls have their own arithmetic, and their vector includes a per-level stride.

A request is a one-cycle pulse. The final vector and state word appear on registered outputs, with a valid strobe, exactly one clock later.

Top module: `ivr_unit`

## Requirements
- R1: Exception classes 1 (system reset), 2 (machine check) and 3 (hypervisor maintenance) are never relocated. Their output vector equals the base vector and their output state equals the input state word.
- R2: Relocation requires both `curIr` and `curDr` to be 1. If either is 0, the output state word equals the input state word.
- R3: With `modelSel` = 1, an interrupt with `curHv` = 0 and bit 60 of `newMsrIn` = 1 is never relocated.
- R4: With `modelSel` = 2, that same escalation is relocated only when `radixMode` = 1.
- R5: With `modelSel` 0 or 3, no request is ever relocated.
- R6: `modeField` values 0 and 1 never relocate. Values 2 and 3 are the active modes.
- R7: When relocation applies, the output state word equals the input state word with bit 5 (instruction relocate) and bit 4 (data relocate) set.
- R8: For a relocated class other than 4, mode 2 ORs 0x18000 into the base vector and mode 3 ORs 0xC000_0000_0000_4000 into it.
- R9: For class 4 (vectored system call), the vector is `baseVector + scvLevel*0x20`. This also holds for a relocated request in mode 2, which adds no further offset but still sets the relocate bits.
- R10: For class 4 relocated in mode 3, the vector is (`baseVector + scvLevel*0x20`) with bits 0x17000 cleared, then ORed with 0xC000_0000_0000_3000.
- R11: `outValid` is high in exactly the cycle after a request cycle, and low otherwise. Synchronous active-high reset clears it.
- R12: `reservedErr` becomes 1 in the cycle after any request made with `modeField` = 1. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | One-cycle interrupt entry request |
| reqClass | input | 3 | Exception class (1 reset, 2 machine check, 3 hyp maintenance, 4 vectored syscall, others generic) |
| curIr | input | 1 | Instruction relocation on in the running state |
| curDr | input | 1 | Data relocation on in the running state |
| curHv | input | 1 | Hypervisor bit of the running state |
| newMsrIn | input | 64 | State word computed for the handler (bit 60 hypervisor) |
| baseVector | input | 64 | Base vector address |
| scvLevel | input | LVL_W | Vectored system call level |
| modeField | input | 2 | Alternate location mode |
| radixMode | input | 1 | Partition uses radix translation |
| modelSel | input | 2 | 0/3 no support, 1 strict escalation, 2 radix-aware |
| outValid | output | 1 | Result strobe, one cycle after the request |
| outVector | output | 64 | Final vector address |
| outMsr | output | 64 | Final state word for the handler |
| reservedErr | output | 1 | Sticky flag for a request made under reserved mode 1 |

## Verification
Suppose the control side takes a wrong relocation decision. On the very next strobe, that shows up at the ports as missing bits 5 and 4 in `outMsr`, or as extra bits in them. A wrong offset selection shows up in the same cycle as a wrong high part or page part of `outVector`. System-call level arithmetic errors show in the low bits of the vector for every class-4 request, whether or not relocation applies. A lost or stuck valid register, or error flag, is visible one clock after the request that should have moved it.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int VEC_W = 64;
  localparam int IR_BIT = 5;
  localparam int DR_BIT = 4;
  localparam int HV_BIT = 60;

  localparam logic [2:0] CLS_SYSRESET = 3'd1;
  localparam logic [2:0] CLS_MCHECK   = 3'd2;
  localparam logic [2:0] CLS_HVMAINT  = 3'd3;
  localparam logic [2:0] CLS_SCV      = 3'd4;

  localparam logic [1:0] MODEL_STRICT = 2'd1;
  localparam logic [1:0] MODEL_RADIX  = 2'd2;

  localparam logic [VEC_W-1:0] OFS_MODE2    = 64'h0000_0000_0001_8000;
  localparam logic [VEC_W-1:0] OFS_MODE3    = 64'hC000_0000_0000_4000;
  localparam logic [VEC_W-1:0] SCV_CLR_MASK = 64'h0000_0000_0001_7000;
  localparam logic [VEC_W-1:0] SCV_OFS3     = 64'hC000_0000_0000_3000;

  typedef struct packed {
    logic load;
    logic reloc;
    logic scvPath;
    logic highMode;
  } ivr_ctrl_t;
endpackage

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
  import ivr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqClass,
  input  logic       curIr,
  input  logic       curDr,
  input  logic       curHv,
  input  logic       newHv,
  input  logic [1:0] modeField,
  input  logic       radixMode,
  input  logic [1:0] modelSel,
  output ivr_ctrl_t  ctrl,
  output logic       outValid,
  output logic       reservedErr
);
  logic exempt;
  logic supported;
  logic escalation;
  logic escBlocked;
  logic modeActive;

  always_comb begin
    exempt     = (reqClass == CLS_SYSRESET) || (reqClass == CLS_MCHECK) ||
                 (reqClass == CLS_HVMAINT);
    supported  = (modelSel == MODEL_STRICT) || (modelSel == MODEL_RADIX);
    escalation = !curHv && newHv;
    escBlocked = escalation && ((modelSel == MODEL_STRICT) || !radixMode);
    modeActive = modeField[1];

    ctrl.load     = reqValid;
    ctrl.reloc    = !exempt && supported && curIr && curDr && !escBlocked && modeActive;
    ctrl.scvPath  = (reqClass == CLS_SCV);
    ctrl.highMode = modeField[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      reservedErr <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid && modeField == 2'b01) begin
        reservedErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivr_datapath.sv
module ivr_datapath
  import ivr_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  ivr_ctrl_t        ctrl,
  input  logic [VEC_W-1:0] newMsrIn,
  input  logic [VEC_W-1:0] baseVector,
  input  logic [LVL_W-1:0] scvLevel,
  output logic [VEC_W-1:0] outVector,
  output logic [VEC_W-1:0] outMsr
);
  localparam int STRIDE_SHIFT = 5;

  logic [VEC_W-1:0] scvVec;
  logic [VEC_W-1:0] nextVec;
  logic [VEC_W-1:0] nextMsr;
  logic [VEC_W-1:0] relocBits;

  always_comb begin
    scvVec    = baseVector + (VEC_W'(scvLevel) << STRIDE_SHIFT);
    relocBits = '0;
    relocBits[IR_BIT] = 1'b1;
    relocBits[DR_BIT] = 1'b1;

    if (ctrl.scvPath) begin
      if (ctrl.reloc && ctrl.highMode) begin
        nextVec = (scvVec & ~SCV_CLR_MASK) | SCV_OFS3;
      end else begin
        nextVec = scvVec;
      end
    end else if (ctrl.reloc) begin
      nextVec = baseVector | (ctrl.highMode ? OFS_MODE3 : OFS_MODE2);
    end else begin
      nextVec = baseVector;
    end

    nextMsr = ctrl.reloc ? (newMsrIn | relocBits) : newMsrIn;
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      outVector <= nextVec;
      outMsr    <= nextMsr;
    end
  end
endmodule

// File: rtl/ivr_unit.sv
module ivr_unit
  import ivr_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [2:0]       reqClass,
  input  logic             curIr,
  input  logic             curDr,
  input  logic             curHv,
  input  logic [63:0]      newMsrIn,
  input  logic [63:0]      baseVector,
  input  logic [LVL_W-1:0] scvLevel,
  input  logic [1:0]       modeField,
  input  logic             radixMode,
  input  logic [1:0]       modelSel,
  output logic             outValid,
  output logic [63:0]      outVector,
  output logic [63:0]      outMsr,
  output logic             reservedErr
);
  ivr_ctrl_t ctrl;

  ivr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqClass   (reqClass),
    .curIr      (curIr),
    .curDr      (curDr),
    .curHv      (curHv),
    .newHv      (newMsrIn[HV_BIT]),
    .modeField  (modeField),
    .radixMode  (radixMode),
    .modelSel   (modelSel),
    .ctrl       (ctrl),
    .outValid   (outValid),
    .reservedErr(reservedErr)
  );

  ivr_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .newMsrIn  (newMsrIn),
    .baseVector(baseVector),
    .scvLevel  (scvLevel),
    .outVector (outVector),
    .outMsr    (outMsr)
  );
endmodule

// File: rtl/ivr_unit_checker.sv
module ivr_unit_checker (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic [2:0]  reqClass,
  input logic        curIr,
  input logic        curDr,
  input logic [1:0]  modeField,
  input logic [1:0]  modelSel,
  input logic [63:0] newMsrIn,
  input logic [63:0] baseVector,
  input logic        outValid,
  input logic [63:0] outVector,
  input logic [63:0] outMsr,
  input logic        reservedErr
);
  a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> outValid);
  a_r11_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !outValid);
  a_r1_exempt_pass: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqClass >= 3'd1 && reqClass <= 3'd3) |=>
      (outVector == $past(baseVector) && outMsr == $past(newMsrIn)));
  a_r2_mmu_off: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !(curIr && curDr)) |=> (outMsr == $past(newMsrIn)));
  a_r5_no_support: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (modelSel == 2'd0 || modelSel == 2'd3)) |=> (outMsr == $past(newMsrIn)));
  a_r6_mode_off: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !modeField[1]) |=> (outMsr == $past(newMsrIn)));
  a_r7_bits_set: assert property (@(posedge clk) disable iff (rst)
    (outValid && outMsr != $past(newMsrIn)) |-> (outMsr[5] && outMsr[4]));
  a_r12_raise: assert property (@(posedge clk) disable iff (rst)
    (reqValid && modeField == 2'b01) |=> reservedErr);
  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    reservedErr |=> reservedErr);
endmodule

bind ivr_unit ivr_unit_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqValid   (reqValid),
  .reqClass   (reqClass),
  .curIr      (curIr),
  .curDr      (curDr),
  .modeField  (modeField),
  .modelSel   (modelSel),
  .newMsrIn   (newMsrIn),
  .baseVector (baseVector),
  .outValid   (outValid),
  .outVector  (outVector),
  .outMsr     (outMsr),
  .reservedErr(reservedErr)
);

// File: tb/ivr_unit_bench.sv
module ivr_unit_bench;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reqValid = 1'b0;
  logic [2:0]       reqClass = '0;
  logic             curIr = 1'b0;
  logic             curDr = 1'b0;
  logic             curHv = 1'b0;
  logic [63:0]      newMsrIn = '0;
  logic [63:0]      baseVector = '0;
  logic [LVL_W-1:0] scvLevel = '0;
  logic [1:0]       modeField = '0;
  logic             radixMode = 1'b0;
  logic [1:0]       modelSel = '0;
  logic             outValid;
  logic [63:0]      outVector;
  logic [63:0]      outMsr;
  logic             reservedErr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ivr_unit #(.LVL_W(LVL_W)) u_ivr_unit (.*);

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic predict(input int cls, input bit ir, input bit dr, input bit hv, input bit nhv,
                         input int mode, input bit rad, input int mdl,
                         input logic [63:0] base, input logic [63:0] msr, input int lvl,
                         output logic [63:0] ev, output logic [63:0] em, output string tag);
    bit reloc = 1'b1;
    bit esc = !hv && nhv;
    tag = "R7";
    if (cls >= 1 && cls <= 3) begin reloc = 0; tag = "R1"; end
    else if (mdl == 0 || mdl == 3) begin reloc = 0; tag = "R5"; end
    else if (!(ir && dr)) begin reloc = 0; tag = "R2"; end
    else if (esc && mdl == 1) begin reloc = 0; tag = "R3"; end
    else if (esc && mdl == 2 && !rad) begin reloc = 0; tag = "R4"; end
    else if (mode < 2) begin reloc = 0; tag = "R6"; end
    ev = base;
    em = msr;
    if (cls == 4) ev = base + 64'(lvl) * 64'h20;
    if (reloc) begin
      em = msr | 64'h30;
      if (cls == 4) begin
        if (mode == 3) begin
          ev = (ev & ~64'h17000) | 64'hC000_0000_0000_3000;
          tag = "R10";
        end else tag = "R9";
      end else begin
        ev = ev | ((mode == 3) ? 64'hC000_0000_0000_4000 : 64'h18000);
        tag = "R8";
      end
    end else if (cls == 4 && tag == "R6") tag = "R9";
  endtask

  task automatic request(input int cls, input bit ir, input bit dr, input bit hv, input bit nhv,
                         input int mode, input bit rad, input int mdl,
                         input logic [63:0] base, input int lvl);
    logic [63:0] ev, em, msr;
    string tag;
    msr = 64'h0000_0000_0000_9001 | (nhv ? (64'h1 << 60) : 64'h0);
    @(negedge clk);
    reqValid = 1'b1; reqClass = 3'(cls); curIr = ir; curDr = dr; curHv = hv;
    newMsrIn = msr; baseVector = base; scvLevel = LVL_W'(lvl);
    modeField = 2'(mode); radixMode = rad; modelSel = 2'(mdl);
    predict(cls, ir, dr, hv, nhv, mode, rad, mdl, base, msr, lvl, ev, em, tag);
    @(posedge clk); #1;
    check("R11", "valid after request", 64'(outValid), 64'd1);
    check(tag, "vector", outVector, ev);
    check(tag, "state", outMsr, em);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    check("R11", "valid idle", 64'(outValid), 64'd0);
  endtask

  initial begin
    #20_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset valid", 64'(outValid), 64'd0);
    check("R12", "reset err", 64'(reservedErr), 64'd0);
    @(negedge clk); rst = 1'b0;

    request(0, 1, 1, 1, 1, 0, 0, 1, 64'h500, 0);
    check("R12", "err after mode 0", 64'(reservedErr), 64'd0);
    request(0, 1, 1, 1, 1, 1, 0, 1, 64'h500, 0);
    check("R12", "err raised by mode 1", 64'(reservedErr), 64'd1);
    request(0, 1, 1, 1, 1, 3, 0, 1, 64'h500, 0);
    check("R12", "err sticky", 64'(reservedErr), 64'd1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R12", "err cleared by reset", 64'(reservedErr), 64'd0);
    check("R11", "valid cleared by reset", 64'(outValid), 64'd0);
    @(negedge clk); rst = 1'b0;

    for (int c = 0; c < 8; c++)
      for (int ir = 0; ir < 2; ir++)
        for (int dr = 0; dr < 2; dr++)
          for (int hv = 0; hv < 2; hv++)
            for (int nh = 0; nh < 2; nh++)
              for (int md = 0; md < 4; md++)
                for (int rd = 0; rd < 2; rd++)
                  for (int ml = 0; ml < 4; ml++) begin
                    int lvl = (c * 37 + md * 11 + ml * 5 + ir + dr * 2 + hv * 3 + nh * 7) % 128;
                    logic [63:0] base;
                    base = (c == 4) ? 64'h17000 : (64'h100 + 64'((c * 8 + md) % 16) * 64'h100);
                    request(c, 1'(ir), 1'(dr), 1'(hv), 1'(nh), md, 1'(rd), ml, base, lvl);
                  end

    request(4, 1, 1, 1, 1, 3, 0, 2, 64'h17000, 127);
    request(4, 1, 1, 1, 1, 2, 0, 2, 64'h17000, 127);
    request(0, 1, 1, 0, 1, 2, 1, 2, 64'hF00, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule